// File: doc/BRIEF.md
# Wrapping Burst Line-Fill Responder

This block sits on the memory side of a 32-bit processor bus and answers cache-line fill reads of 16 bytes. While a burst is running, the processor keeps its address bus fixed at the starting address. The responder therefore latches that address once, when the cycle opens. It then produces the long-word index itself. The index starts at the latched value of bits 3:2, counts upward, and wraps from 3 back to 0 inside the same line. One long word is returned per beat, each marked by a single-cycle termination strobe.

A cycle opens when the processor raises its cycle-valid line. The responder grants a burst by raising its acknowledge only if three things hold: a burst is requested, the access is a read, and the access is a long-word-aligned long-word transfer. Any other access completes as one transfer.

A burst can end in four ways:
- after the fourth word;
- when the processor withdraws its request;
- when the memory side asserts its stop input;
- when the processor releases the cycle.

A small word array, filled at reset with a computed pattern, stands in for the memory.

Top module: `linefill_responder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `term_o` and `burst_ack_o` are low.
- R2: `burst_ack_o` goes high in the cycle after the opening edge only if, at that edge, `burst_req_i` is 1, `rd_i` is 1, `size_i` is 2'b00 (four bytes) and `addr_i[1:0]` is 2'b00. In every other case, exactly one strobe is issued.
- R3: `term_o` is high for exactly one cycle per beat. Its first pulse comes WAIT_CYCLES+1 cycles after the opening edge, and successive pulses are WAIT_CYCLES+1 cycles apart.
- R4: While `term_o` is high, `data_o` holds the store word at index k = `word_addr_o[MEM_AW+1:2]`, and that word equals {k[15:0] ^ 16'hC3A5, k[15:0]}.
- R5: The first beat's `word_addr_o[3:2]` equals the opening `addr_i[3:2]`. Each later beat adds 1 modulo 4, and `word_addr_o[1:0]` is 0.
- R6: `word_addr_o[31:4]` equals the opening `addr_i[31:4]` for every beat of the cycle, including after the index wraps.
- R7: A cycle produces no more than four strobes.
- R8: If `burst_req_i` is low in the strobe cycle of a beat, that beat is the last one and `burst_ack_o` is low in the following cycle.
- R9: If `stop_burst_i` is high in the strobe cycle of a beat, that beat is the last one and `burst_ack_o` is low in the following cycle.
- R10: In the cycle after `cyc_valid_i` is sampled low, `term_o` and `burst_ack_o` are low, even in the middle of a burst. A finished cycle gives no further strobe while `cyc_valid_i` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_valid_i | input | 1 | Processor holds a bus cycle open (address, data strobe and buffer enable active) |
| addr_i | input | 32 | Processor address, held constant for the cycle |
| rd_i | input | 1 | 1 for a read |
| size_i | input | 2 | Transfer size; 2'b00 means four bytes |
| burst_req_i | input | 1 | Processor asks for a line burst |
| stop_burst_i | input | 1 | Memory side wants the burst ended after the current beat |
| burst_ack_o | output | 1 | Burst granted and still continuing |
| term_o | output | 1 | One-cycle termination strobe per beat |
| data_o | output | 32 | Read data, valid with `term_o` |
| word_addr_o | output | 32 | Long-word address served by the current beat |

## Verification
The hardest situations to reach are a wrapping burst that is cut short at a chosen beat by one side or the other, and a release of the cycle between two beats of a live burst. The bench reaches them by watching the strobes. It counts beats as they arrive, then drops the request or raises the stop input during the strobe of beat n, or lowers cycle-valid during a wait period. It does this for every starting offset and for two lines whose upper address bits differ.

// File: rtl/lf_pkg.sv
// Shared types and the data pattern of the line-fill responder.
// Assumes a 32-bit bus with four long words per line.
package lf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BEAT = 2'd2,
        ST_DONE = 2'd3
    } lf_state_t;

    localparam logic [1:0] SIZE_LONG = 2'b00;

    // Content of store word k, used to fill the model at reset.
    function automatic logic [31:0] line_word(input logic [15:0] k);
        return {k ^ 16'hC3A5, k};
    endfunction

endpackage

// File: rtl/lf_wait_timer.sv
// Counts the wait cycles in front of each beat.
// The count runs while run is high and restarts at zero whenever run is low.
// Assumes WAIT_CYCLES >= 1.
module lf_wait_timer #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Advance the count while waiting; restart it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + CW'(1);
        else cnt_q <= '0;
    end

    assign expired = run && (cnt_q == CW'(WAIT_CYCLES - 1));
endmodule

// File: rtl/lf_wrap_counter.sv
// Long-word index within the line, plus the number of beats delivered.
// The index is loaded from the start address, steps upward and wraps
// inside the line. The beat number tells the controller when the final
// beat is reached.
module lf_wrap_counter #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             last_beat
);
    localparam int BEATS = 1 << IDX_W;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] beat_q;

    // Load on cycle start; step index and beat on each continued beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            beat_q <= '0;
        end else if (load) begin
            idx_q  <= load_idx;
            beat_q <= '0;
        end else if (advance) begin
            idx_q  <= idx_q + IDX_W'(1);
            beat_q <= beat_q + IDX_W'(1);
        end
    end

    assign idx       = idx_q;
    assign last_beat = (beat_q == IDX_W'(BEATS - 1));
endmodule

// File: rtl/lf_line_store.sv
// Synchronous word-array memory model with a registered read.
// Reset fills every word with the package pattern. Read data for an index
// appears one clock after the index is presented.
module lf_line_store #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [31:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    // Fill the array on reset, otherwise register the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= lf_pkg::line_word(16'(i));
            rdata <= '0;
        end else begin
            rdata <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/linefill_responder.sv
// Memory-side responder for wrapping 16-byte line-fill bursts.
// It latches the line address when a cycle opens and generates the wrapping
// long-word index itself. Each beat is a strobe issued after a fixed wait.
// The burst ends after four words, on a withdrawn request, on a stop from
// the memory side, or when the cycle is released.
// Assumes WAIT_CYCLES >= 1 and MEM_AW >= 3.
module linefill_responder #(
    parameter int WAIT_CYCLES = 2,
    parameter int MEM_AW      = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_valid_i,
    input  logic [31:0] addr_i,
    input  logic        rd_i,
    input  logic [1:0]  size_i,
    input  logic        burst_req_i,
    input  logic        stop_burst_i,
    output logic        burst_ack_o,
    output logic        term_o,
    output logic [31:0] data_o,
    output logic [31:0] word_addr_o
);
    import lf_pkg::*;

    localparam int IDX_W     = 2;
    localparam int LINE_W    = 32 - IDX_W - 2;
    localparam int LINE_SEL  = MEM_AW - IDX_W;

    lf_state_t         state_q, state_d;
    logic [LINE_W-1:0] line_q;
    logic              bmode_q, bmode_d;
    logic              start, eligible, keep, expired, last_beat;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       rdata;

    assign start    = (state_q == ST_IDLE) && cyc_valid_i;
    assign eligible = burst_req_i && rd_i && (size_i == SIZE_LONG) && (addr_i[1:0] == 2'b00);
    assign keep     = bmode_q && burst_req_i && !stop_burst_i && !last_beat;

    // Next state and burst grant for the bus cycle.
    always_comb begin
        state_d = state_q;
        bmode_d = bmode_q;
        unique case (state_q)
            ST_IDLE: begin
                bmode_d = 1'b0;
                if (cyc_valid_i) begin
                    state_d = ST_WAIT;
                    bmode_d = eligible;
                end
            end
            ST_WAIT: begin
                bmode_d = bmode_q && burst_req_i && !stop_burst_i;
                if (expired) state_d = ST_BEAT;
            end
            ST_BEAT: begin
                bmode_d = keep;
                state_d = keep ? ST_WAIT : ST_DONE;
            end
            ST_DONE: bmode_d = 1'b0;
            default: state_d = ST_IDLE;
        endcase
        if (!cyc_valid_i) begin
            state_d = ST_IDLE;
            bmode_d = 1'b0;
        end
    end

    // State, grant and line address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bmode_q <= 1'b0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            bmode_q <= bmode_d;
            if (start) line_q <= addr_i[31:4];
        end
    end

    lf_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_WAIT),
        .expired (expired)
    );

    lf_wrap_counter #(.IDX_W(IDX_W)) u_wrap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_idx  (addr_i[3:2]),
        .advance   ((state_q == ST_BEAT) && keep && cyc_valid_i),
        .idx       (idx),
        .last_beat (last_beat)
    );

    lf_line_store #(.AW(MEM_AW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx ({line_q[LINE_SEL-1:0], idx}),
        .rdata  (rdata)
    );

    assign term_o      = (state_q == ST_BEAT);
    assign burst_ack_o = bmode_q;
    assign data_o      = rdata;
    assign word_addr_o = {line_q, idx, 2'b00};
endmodule

// File: rtl/lf_checker.sv
// Bus-level properties of the line-fill responder, bound to its top module.
module lf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_valid_i,
    input logic [31:0] addr_i,
    input logic        rd_i,
    input logic [1:0]  size_i,
    input logic        burst_req_i,
    input logic        stop_burst_i,
    input logic        burst_ack_o,
    input logic        term_o,
    input logic [31:0] word_addr_o
);
    logic [2:0] beats_seen;

    // Count strobes within the open cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !cyc_valid_i) beats_seen <= '0;
        else if (term_o) beats_seen <= beats_seen + 3'd1;
    end

    // R2
    ack_needs_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_ack_o) |-> $past(burst_req_i && rd_i && size_i == 2'b00 && addr_i[1:0] == 2'b00));

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> !term_o);

    // R5
    index_steps_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid_i && $past(cyc_valid_i) && $past(cyc_valid_i, 2) &&
         word_addr_o[3:2] != $past(word_addr_o[3:2]))
        |-> word_addr_o[3:2] == $past(word_addr_o[3:2]) + 2'd1);

    // R6
    line_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid_i && $past(cyc_valid_i) && $past(cyc_valid_i, 2)) |-> $stable(word_addr_o[31:4]));

    // R7
    four_beats_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_o && cyc_valid_i) |-> beats_seen < 3'd4);

    // R8
    req_drop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_ack_o && !burst_req_i) |=> !burst_ack_o);

    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_ack_o && stop_burst_i) |=> !burst_ack_o);

    // R10
    release_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid_i |=> (!term_o && !burst_ack_o));
endmodule

bind linefill_responder lf_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_valid_i  (cyc_valid_i),
    .addr_i       (addr_i),
    .rd_i         (rd_i),
    .size_i       (size_i),
    .burst_req_i  (burst_req_i),
    .stop_burst_i (stop_burst_i),
    .burst_ack_o  (burst_ack_o),
    .term_o       (term_o),
    .word_addr_o  (word_addr_o)
);

// File: tb/tb_linefill_responder.sv
// Sweeps every start offset, request-drop beat and stop beat over two lines;
// expected words and addresses are computed arithmetically.
module tb_linefill_responder;
    localparam int W  = 2;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cyc_valid_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        rd_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic        burst_req_i = 1'b0;
    logic        stop_burst_i = 1'b0;
    logic        burst_ack_o, term_o;
    logic [31:0] data_o, word_addr_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    linefill_responder #(.WAIT_CYCLES(W), .MEM_AW(AW)) dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] wa);
        logic [15:0] k;
        k = 16'((wa >> 2) & ((1 << AW) - 1));
        return {k ^ 16'hC3A5, k};
    endfunction

    // One bus cycle; drop_at/stop_at name the beat (1..4) where that side ends, 0 for never.
    task automatic run_cycle(input logic [31:0] a, input logic rd, input logic [1:0] sz,
                             input logic req, input int drop_at, input int stop_at);
        bit elig;
        int exp_beats, seen, gap;
        logic [1:0] idx;
        @(negedge clk);
        addr_i = a; rd_i = rd; size_i = sz; burst_req_i = req; stop_burst_i = 1'b0;
        cyc_valid_i = 1'b1;
        elig = req && rd && sz == 2'b00 && a[1:0] == 2'b00;
        exp_beats = 1;
        if (elig) begin
            exp_beats = 4;
            if (drop_at != 0 && drop_at < exp_beats) exp_beats = drop_at;
            if (stop_at != 0 && stop_at < exp_beats) exp_beats = stop_at;
        end
        idx = a[3:2]; seen = 0; gap = 0;
        for (int c = 0; c < (exp_beats + 3) * (W + 1); c++) begin
            @(negedge clk);
            gap++;
            if (term_o) begin
                seen++;
                chk(seen <= exp_beats, "R7/R8/R9 extra strobe", seen, exp_beats);
                chk(gap == W + 1, "R3 strobe spacing", gap, W + 1);
                chk(word_addr_o == {a[31:4], idx, 2'b00}, "R5/R6 beat address", word_addr_o, {a[31:4], idx, 2'b00});
                chk(data_o == exp_word({a[31:4], idx, 2'b00}), "R4 beat data", data_o, exp_word({a[31:4], idx, 2'b00}));
                if (seen == 1) chk(burst_ack_o == elig, "R2 grant", burst_ack_o, elig);
                idx = idx + 2'd1;
                gap = 0;
                if (seen == drop_at) burst_req_i = 1'b0;
                if (seen == stop_at) stop_burst_i = 1'b1;
            end
        end
        chk(seen == exp_beats, "R7/R8/R9 beat count", seen, exp_beats);
        chk(burst_ack_o == 1'b0, "R8/R9/R10 grant dropped", burst_ack_o, 0);
        cyc_valid_i = 1'b0; burst_req_i = 1'b0; stop_burst_i = 1'b0;
        @(negedge clk);
        chk(!term_o && !burst_ack_o, "R10 idle after release", {term_o, burst_ack_o}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] lines [2];
        lines[0] = 32'h0000_0040;
        lines[1] = 32'hFEDC_BA90;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!term_o && !burst_ack_o, "R1 reset outputs", {term_o, burst_ack_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!term_o && !burst_ack_o, "R1 after reset", {term_o, burst_ack_o}, 0);

        for (int l = 0; l < 2; l++)
            for (int off = 0; off < 4; off++)
                for (int drop = 0; drop < 4; drop++)
                    for (int st = 0; st < 4; st += 2)
                        run_cycle(lines[l] | 32'(off << 2), 1'b1, 2'b00, 1'b1, drop, st);

        for (int st = 1; st < 4; st++)
            run_cycle(32'h1234_5678 & ~32'h3 | 32'h8, 1'b1, 2'b00, 1'b1, 0, st);

        // R2 ineligible accesses complete as single transfers.
        run_cycle(32'h0000_00CC, 1'b0, 2'b00, 1'b1, 0, 0);
        run_cycle(32'h0000_00CC, 1'b1, 2'b01, 1'b1, 0, 0);
        run_cycle(32'h0000_00CE, 1'b1, 2'b00, 1'b1, 0, 0);
        run_cycle(32'h0000_00CC, 1'b1, 2'b00, 1'b0, 0, 0);

        // R10 release in the middle of a burst.
        @(negedge clk);
        addr_i = 32'hA000_0034; rd_i = 1'b1; size_i = 2'b00; burst_req_i = 1'b1; cyc_valid_i = 1'b1;
        while (!term_o) @(negedge clk);
        @(negedge clk);
        cyc_valid_i = 1'b0;
        for (int c = 0; c < 4 * (W + 1); c++) begin
            @(negedge clk);
            chk(!term_o && !burst_ack_o, "R10 release mid-burst", {term_o, burst_ack_o}, 0);
        end
        burst_req_i = 1'b0;
        run_cycle(32'hA000_0034, 1'b1, 2'b00, 1'b1, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule